// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital side of an analog voltage comparator. The analog result comes in as one asynchronous bit. The block brings it into the bus clock domain through a flop synchronizer and watches it for edges. When the chosen kind of edge appears, it sets a sticky event flag. If interrupts are enabled, that flag raises an interrupt request. A small register port holds the configuration: enable, interrupt enable, edge mode, reference choice and output-pin enable. The same port carries the write-one-to-clear bit for the flag, and the full configuration plus the flag can be read back on it.

The block also follows the chip's power mode, which arrives on a three-bit status input. Run, wait and debug all behave the same. The light stop state freezes every register and resumes cleanly afterwards. The deep stop states return the block to its reset contents. Edge detection is masked for a short window after the block is enabled, after the reference choice changes and after a resume from light stop. This masking keeps analog settling and a stale synchronizer from producing false flags.

Top module: `cmp_edge_irq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` reads 0, and `irq_o`, `cmp_out`, `ref_sel_o` and `ana_en` are all 0.
- R2: The control word is written through `reg_wdata`. Bit 0 enables the block, bit 1 enables the interrupt, bits 3:2 hold the edge mode, bit 4 selects the reference, bit 5 enables the output pin, and bit 6 clears the flag when written as 1. The edge modes are: 2'b00 flags falling edges only, 2'b01 flags rising edges only, and 2'b10 or 2'b11 flag both kinds. An edge of the wrong kind leaves the flag at 0.
- R3: The flag reads back on `ctl_rdata[6]`. Once set, it stays set until a write with bit 6 high clears it. If a new qualifying edge lands in the same cycle as such a clear, the flag stays set.
- R4: `irq_o` is high exactly while the flag, the interrupt enable and the block enable are all set and the chip is not in a stop mode.
- R5: `ref_sel_o` follows control bit 4. It tells the analog side to compare against the internal bandgap (1) or the external reference (0).
- R6: A change of the reference choice, or the enable going from 0 to 1, masks edge detection in that cycle and for MASK_CYCLES further cycles. An input edge that reaches the detector inside that window is not flagged.
- R7: `cmp_out` shows the synchronized comparator level while control bits 5 and 0 are both set and the chip is not in stop. Otherwise it is 0.
- R8: Wait (`pm_mode` = 3'b001) and debug (3'b010) behave like run (3'b000). Edges are detected, writes take effect and `irq_o` can assert.
- R9: In light stop (`pm_mode` = 3'b100), register writes and input changes have no effect, and `ctl_rdata` is held. On return to run, the prior configuration and flag are back. A level change made during the freeze produces no flag. If light stop ends through reset, the state of R1 applies.
- R10: In deep stop (`pm_mode` = 3'b101, 3'b110 or 3'b111), all control fields and the flag return to 0, and they still read 0 after the return to run.
- R11: In any stop mode (`pm_mode[2]` = 1), `irq_o` and `ana_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 7 | Control write data; bit 6 is flag clear |
| pm_mode | input | 3 | Power mode status: run, wait, debug, light stop, deep stop |
| cmp_raw | input | 1 | Asynchronous analog comparator result |
| ctl_rdata | output | 7 | Read-back of control fields with the flag in bit 6 |
| irq_o | output | 1 | Interrupt request |
| cmp_out | output | 1 | Synchronized comparator level for the output pin |
| ref_sel_o | output | 1 | Reference choice sent to the analog comparator |
| ana_en | output | 1 | Power enable for the analog comparator |

## Verification
Several properties are checked on every cycle. The interrupt is never raised without flag and enables. Nothing is requested or powered during stop. The read-back does not move while light stop lasts. Deep stop empties the registers. The flag never drops without a clearing write, and the pin only drives when enabled. Other behaviour can only be shown by the bench's scenarios, because each depends on a timed sequence of input edges: the edge-mode selection, the priority of a set over a same-cycle clear, the settling masks after enable and reference changes, and the absence of a false edge after a resume.

// File: rtl/cmp_edge_pkg.sv
package cmp_edge_pkg;

   localparam int CTL_W    = 7;
   localparam int FLAG_BIT = 6;

   typedef enum logic [1:0] {
      EDGE_FALL     = 2'b00,
      EDGE_RISE     = 2'b01,
      EDGE_BOTH     = 2'b10,
      EDGE_BOTH_ALT = 2'b11
   } edge_mode_t;

   typedef struct packed {
      logic       pin_en;
      logic       ref_sel;
      edge_mode_t edge_mode;
      logic       irq_en;
      logic       enable;
   } ctl_t;

   // Power mode decode: bit 2 marks any stop state; light stop is 3'b100.
   function automatic logic pm_is_stop(input logic [2:0] m);
      return m[2];
   endfunction

   function automatic logic pm_is_deep(input logic [2:0] m);
      return m[2] & (|m[1:0]);
   endfunction

   function automatic logic pm_is_light(input logic [2:0] m);
      return m[2] & ~(|m[1:0]);
   endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic clear,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmp_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else if (clear) begin
         chain <= '0;
      end else if (!hold) begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
   import cmp_edge_pkg::*;
#(
   parameter int MASK_CYCLES   = 2,
   parameter int RESUME_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       clear,
   input  logic       enable,
   input  logic       ref_sel,
   input  logic       resume,
   input  logic       level,
   input  edge_mode_t edge_mode,
   output logic       hit
);

   localparam int LOAD_MAX = (MASK_CYCLES > RESUME_CYCLES) ? MASK_CYCLES : RESUME_CYCLES;
   localparam int CW       = $clog2(LOAD_MAX + 1);

   logic          prev_lvl;
   logic          en_d;
   logic          ref_d;
   logic [CW-1:0] mask_cnt;
   logic          start_mask;
   logic          masked;
   logic          rise;
   logic          fall;
   logic          sel_edge;

   assign start_mask = (enable & ~en_d) | (ref_sel != ref_d);
   assign masked     = start_mask | resume | (mask_cnt != '0);
   assign rise       = level & ~prev_lvl;
   assign fall       = ~level & prev_lvl;

   always_comb begin
      case (edge_mode)
         EDGE_FALL:     sel_edge = fall;
         EDGE_RISE:     sel_edge = rise;
         EDGE_BOTH,
         EDGE_BOTH_ALT: sel_edge = rise | fall;
         default:       sel_edge = 1'b0;
      endcase
   end

   assign hit = enable & ~masked & sel_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         en_d     <= 1'b0;
         ref_d    <= 1'b0;
         mask_cnt <= '0;
      end else if (clear) begin
         prev_lvl <= 1'b0;
         en_d     <= 1'b0;
         ref_d    <= 1'b0;
         mask_cnt <= '0;
      end else if (!hold) begin
         prev_lvl <= level;
         en_d     <= enable;
         ref_d    <= ref_sel;
         if (resume) begin
            mask_cnt <= CW'(RESUME_CYCLES);
         end else if (start_mask) begin
            mask_cnt <= CW'(MASK_CYCLES);
         end else if (mask_cnt != '0) begin
            mask_cnt <= mask_cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic clear,
   input  logic set,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (clear) begin
         flag <= 1'b0;
      end else if (!hold) begin
         if (set) begin
            flag <= 1'b1;
         end else if (clr_req) begin
            flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cmp_edge_irq_ctrl.sv
module cmp_edge_irq_ctrl
   import cmp_edge_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MASK_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [CTL_W-1:0] reg_wdata,
   input  logic [2:0]       pm_mode,
   input  logic             cmp_raw,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             irq_o,
   output logic             cmp_out,
   output logic             ref_sel_o,
   output logic             ana_en
);

   localparam int RESUME_CYCLES = SYNC_STAGES;

   generate
      if (MASK_CYCLES < 1) begin : g_bad_mask
         $error("cmp_edge_irq_ctrl: MASK_CYCLES must be at least 1");
      end
      if ($bits(ctl_t) != CTL_W - 1) begin : g_bad_layout
         $error("cmp_edge_irq_ctrl: control layout does not match CTL_W");
      end
   endgenerate

   ctl_t ctl_q;
   logic stop_any;
   logic stop_light;
   logic stop_deep;
   logic stop_d;
   logic resume;
   logic sync_lvl;
   logic edge_hit;
   logic flag_q;
   logic clr_req;

   assign stop_any   = pm_is_stop(pm_mode);
   assign stop_light = pm_is_light(pm_mode);
   assign stop_deep  = pm_is_deep(pm_mode);
   assign resume     = stop_d & ~stop_any;
   assign clr_req    = reg_we & reg_wdata[FLAG_BIT] & ~stop_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_d <= 1'b0;
      end else begin
         stop_d <= stop_any;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (stop_deep) begin
         ctl_q <= '0;
      end else if (reg_we && !stop_any) begin
         ctl_q <= ctl_t'(reg_wdata[CTL_W-2:0]);
      end
   end

   cmp_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (stop_light),
      .clear (stop_deep),
      .d     (cmp_raw),
      .q     (sync_lvl)
   );

   cmp_edge_det #(
      .MASK_CYCLES   (MASK_CYCLES),
      .RESUME_CYCLES (RESUME_CYCLES)
   ) i_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (stop_light),
      .clear     (stop_deep),
      .enable    (ctl_q.enable),
      .ref_sel   (ctl_q.ref_sel),
      .resume    (resume),
      .level     (sync_lvl),
      .edge_mode (ctl_q.edge_mode),
      .hit       (edge_hit)
   );

   cmp_flag i_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (stop_light),
      .clear   (stop_deep),
      .set     (edge_hit),
      .clr_req (clr_req),
      .flag    (flag_q)
   );

   assign ctl_rdata = {flag_q, ctl_q};
   assign irq_o     = flag_q & ctl_q.irq_en & ctl_q.enable & ~stop_any;
   assign cmp_out   = sync_lvl & ctl_q.pin_en & ctl_q.enable & ~stop_any;
   assign ref_sel_o = ctl_q.ref_sel;
   assign ana_en    = ctl_q.enable & ~stop_any;

endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [6:0] reg_wdata,
   input logic [2:0] pm_mode,
   input logic [6:0] ctl_rdata,
   input logic       irq_o,
   input logic       cmp_out,
   input logic       ref_sel_o,
   input logic       ana_en
);

   a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ctl_rdata[6] && ctl_rdata[1] && ctl_rdata[0]));

   a_r11_quiet_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      pm_mode[2] |-> (!irq_o && !ana_en));

   a_r10_deep_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pm_mode[2] && (pm_mode[1:0] != 2'b00)) |-> (ctl_rdata == 7'd0 && !irq_o));

   a_r9_light_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pm_mode) == 3'b100) |-> $stable(ctl_rdata));

   a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_rdata[6] && !(reg_we && reg_wdata[6]) && !(pm_mode[2] && (pm_mode[1:0] != 2'b00)))
      |-> ctl_rdata[6]);

   a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_out |-> (ctl_rdata[5] && ctl_rdata[0] && !pm_mode[2]));

   a_r5_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ref_sel_o == ctl_rdata[4]);

endmodule

bind cmp_edge_irq_ctrl cmp_edge_irq_chk i_chk (.*);

// File: tb/test_cmp_edge_irq_ctrl.sv
module test_cmp_edge_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [6:0] reg_wdata = '0;
   logic [2:0] pm_mode = 3'b000;
   logic       cmp_raw = 1'b0;
   logic [6:0] ctl_rdata;
   logic       irq_o;
   logic       cmp_out;
   logic       ref_sel_o;
   logic       ana_en;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cmp_edge_irq_ctrl i_cmp_edge_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .pm_mode   (pm_mode),
      .cmp_raw   (cmp_raw),
      .ctl_rdata (ctl_rdata),
      .irq_o     (irq_o),
      .cmp_out   (cmp_out),
      .ref_sel_o (ref_sel_o),
      .ana_en    (ana_en)
   );

   // {edge_mode[1:0], start level, end level, expected flag}
   localparam logic [4:0] VEC [8] = '{
      {2'b00, 1'b1, 1'b0, 1'b1},
      {2'b00, 1'b0, 1'b1, 1'b0},
      {2'b01, 1'b0, 1'b1, 1'b1},
      {2'b01, 1'b1, 1'b0, 1'b0},
      {2'b10, 1'b0, 1'b1, 1'b1},
      {2'b10, 1'b1, 1'b0, 1'b1},
      {2'b11, 1'b0, 1'b1, 1'b1},
      {2'b11, 1'b1, 1'b0, 1'b1}
   };

   function automatic logic [6:0] cfg(input logic clr, input logic pin, input logic rs,
                                      input logic [1:0] em, input logic ie, input logic en);
      return {clr, pin, rs, em, ie, en};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] d);
      reg_we    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 rdata", ctl_rdata, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 pin", cmp_out, 0);
      chk("R1 ref", ref_sel_o, 0);
      chk("R1 ana_en", ana_en, 0);

      // R2 edge modes from the vector table
      for (int i = 0; i < 8; i++) begin
         cmp_raw = VEC[i][2];
         tick(6);
         wr(cfg(1'b1, 1'b0, 1'b0, VEC[i][4:3], 1'b0, 1'b1));
         tick(1);
         cmp_raw = VEC[i][1];
         tick(5);
         chk($sformatf("R2 vector %0d flag", i), ctl_rdata[6], VEC[i][0]);
      end

      // R4 interrupt gating by enable bit
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1));
      cmp_raw = 1'b1;
      tick(5);
      chk("R4 irq with ie=0", irq_o, 0);
      chk("R3 flag set", ctl_rdata[6], 1);
      wr(cfg(1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
      tick(1);
      chk("R4 irq with ie=1", irq_o, 1);

      // R3 sticky flag and clear
      wr(cfg(1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1));
      cmp_raw = 1'b0;
      tick(5);
      chk("R3 flag sticky", ctl_rdata[6], 1);
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1));
      tick(1);
      chk("R3 flag cleared", ctl_rdata[6], 0);
      chk("R4 irq dropped", irq_o, 0);

      // R3 set wins over same-cycle clear
      cmp_raw = 1'b1;
      tick(2);
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1));
      chk("R3 set over clear", ctl_rdata[6], 1);
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1));
      tick(1);
      chk("R3 cleared again", ctl_rdata[6], 0);

      // R7 output pin
      wr(cfg(1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1));
      tick(1);
      chk("R7 pin high", cmp_out, 1);
      cmp_raw = 1'b0;
      tick(4);
      chk("R7 pin low", cmp_out, 0);
      cmp_raw = 1'b1;
      tick(4);
      wr(cfg(1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1));
      tick(1);
      chk("R7 pin disabled", cmp_out, 0);

      // R5 reference select
      wr(cfg(1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1));
      tick(1);
      chk("R5 ref high", ref_sel_o, 1);

      // R6 mask on reference change
      wr(cfg(1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1));
      tick(5);
      cmp_raw = 1'b0;
      wr(cfg(1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
      tick(5);
      chk("R6 masked after ref change", ctl_rdata[6], 0);
      chk("R5 ref low", ref_sel_o, 0);
      cmp_raw = 1'b1;
      tick(5);
      chk("R6 unmasked edge", ctl_rdata[6], 1);

      // R6 mask on enable
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0));
      cmp_raw = 1'b0;
      tick(5);
      chk("R6 disabled no flag", ctl_rdata[6], 0);
      cmp_raw = 1'b1;
      wr(cfg(1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
      tick(5);
      chk("R6 masked after enable", ctl_rdata[6], 0);

      // R8 wait and debug
      pm_mode = 3'b001;
      cmp_raw = 1'b0;
      tick(5);
      chk("R8 irq in wait", irq_o, 1);
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
      tick(1);
      chk("R8 clear in wait", irq_o, 0);
      pm_mode = 3'b010;
      cmp_raw = 1'b1;
      tick(5);
      chk("R8 irq in debug", irq_o, 1);
      pm_mode = 3'b000;
      tick(1);

      // R9 / R11 light stop freeze and resume
      pm_mode = 3'b100;
      tick(1);
      chk("R11 irq off in light stop", irq_o, 0);
      chk("R11 analog off in light stop", ana_en, 0);
      wr(cfg(1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0));
      cmp_raw = 1'b0;
      tick(5);
      chk("R9 state held", ctl_rdata, 7'h4B);
      pm_mode = 3'b000;
      tick(1);
      chk("R9 irq back after resume", irq_o, 1);
      chk("R9 state after resume", ctl_rdata, 7'h4B);
      wr(cfg(1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
      tick(5);
      chk("R9 no false edge after resume", ctl_rdata[6], 0);

      // R9 light stop left through reset
      pm_mode = 3'b100;
      tick(2);
      rst_n = 1'b0;
      pm_mode = 3'b000;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      chk("R9 reset exit state", ctl_rdata, 0);

      // R10 deep stop
      tick(3);
      wr(cfg(1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1));
      tick(5);
      cmp_raw = 1'b1;
      tick(5);
      chk("R4 irq before deep stop", irq_o, 1);
      pm_mode = 3'b110;
      tick(1);
      chk("R10 cleared in deep stop", ctl_rdata, 0);
      chk("R11 irq off in deep stop", irq_o, 0);
      pm_mode = 3'b000;
      tick(1);
      chk("R10 cleared after wake", ctl_rdata, 0);
      chk("R10 ref after wake", ref_sel_o, 0);
      chk("R10 pin after wake", cmp_out, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule